// File: doc/BRIEF.md
# DRAM Per-Bank Command Order Monitor

This block is a passive observer placed beside a DRAM controller's command output. Each clock cycle it may see one command, a bank number and a mode level. For every bank it remembers the last DRAM command issued to that bank. When a new command arrives, the block checks whether it is an allowed follower of the remembered one. Two successor tables are built in. One fits controllers that manage each bank on its own. The other fits controllers that precharge, refresh and power down all banks together. Only the order of commands is checked. Timing distances and data are not looked at.

The command input is a stream carrying only a valid strobe. The monitor accepts every beat in the cycle it is offered, so it has no ready signal and never applies back-pressure. Codes that are not DRAM commands, such as request or response markers, may share the stream and are skipped. When a transition is illegal, the block raises a one-cycle report one clock after the offending beat. The report carries the bank, the previous code and the offending code. A sticky flag records that at least one violation has occurred.

Command codes on `cmd_code`: 0 precharge, 1 precharge-all, 2 activate, 3 read, 4 read with auto-precharge, 5 write, 6 write with auto-precharge, 7 refresh, 8 active power-down, 9 precharged power-down, 10 self-refresh. Codes 11 to 15 are not DRAM commands.

Top module: `dram_cmd_order_mon`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `err_pulse` and `err_sticky` are 0. Reset erases every bank's history.
- R2: The first DRAM command seen on a bank after reset never raises an error, whatever its code and whatever the mode.
- R3: With `all_bank_mode`=0 the allowed successors are as follows. Precharge (0) is followed by 2 or 7. Activate (2) is followed by 3, 4, 5 or 6. Read (3) and write (5) are followed by 0, 3, 4, 5, 6 or 8. The auto-precharge accesses (4, 6) are followed by 2, 7 or 9. Refresh (7) is followed by 2, 9 or 10. Active power-down (8) is followed by 0, 3, 4, 5, 6 or 7. Precharged power-down (9) is followed by 2 or 7. Self-refresh (10) is followed only by 2. Precharge-all (1) has no allowed successor and is the successor of nothing, so any use of it after history exists is flagged.
- R4: With `all_bank_mode`=1 the allowed successors are as follows. Precharge (0) is followed only by 2. Precharge-all (1) is followed only by 7. Activate (2) is followed by 3 to 6. Read (3) and write (5) are followed by 0, 1, 3, 4, 5, 6 or 8. The codes 4, 6, 9 and 10 are each followed by 1, 2, 7, 8 or 9. Refresh (7) is followed by 1, 2, 7, 8, 9 or 10. Active power-down (8) is followed by any of 0 to 9.
- R5: An illegal transition sampled at a clock edge makes `err_pulse` 1 for exactly the following cycle, unless that next beat is illegal too. During that cycle `err_bank`, `err_prev` and `err_curr` hold the bank, the stored previous code and the offending code.
- R6: `err_sticky` rises together with the first `err_pulse` and stays 1 until reset.
- R7: A cycle with `cmd_valid`=0, or with a code from 11 to 15, raises no error and leaves every bank's history unchanged.
- R8: History is kept per bank. A command on one bank does not change the stored command of any other bank. The stored command becomes the new code even when that code was flagged.
- R9: The table is chosen by the level of `all_bank_mode` in the same cycle as each command, so the mode may change between commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Stream beat present this cycle |
| cmd_code | input | 4 | Command code (see encoding above) |
| cmd_bank | input | BANK_W (3) | Target bank of the command |
| all_bank_mode | input | 1 | 0 selects the per-bank table, 1 selects the all-bank table |
| err_pulse | output | 1 | One-cycle violation report |
| err_bank | output | BANK_W (3) | Bank of the reported violation |
| err_prev | output | 4 | Stored previous code of that bank |
| err_curr | output | 4 | Offending code |
| err_sticky | output | 1 | Set by any violation, cleared by reset |

## Verification
The embedded properties watch every cycle for several things. Every report must trace back to a real beat of the stream on the reported bank with the reported code. A skipped beat must never be reported. The sticky flag must rise with the first report and never fall. At most one bank's history may be written per cycle. Whether each of the many code pairs is judged correctly in each mode can only be shown by the bench. So can the acceptance of the first command per bank, the keeping of a flagged code as the new history, the clearing of history by a mid-run reset, and mode changes between commands. The bench drives directed sequences and a long seeded random stream for these cases.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int CODE_W   = 4;
  localparam int NUM_CMDS = 11;

  typedef enum logic [CODE_W-1:0] {
    OP_PRECH    = 4'd0,
    OP_PRECHALL = 4'd1,
    OP_ACTV     = 4'd2,
    OP_READ     = 4'd3,
    OP_READAP   = 4'd4,
    OP_WRITE    = 4'd5,
    OP_WRITEAP  = 4'd6,
    OP_REFR     = 4'd7,
    OP_PDACT    = 4'd8,
    OP_PDPRE    = 4'd9,
    OP_SELFREF  = 4'd10
  } dram_op_e;

  typedef logic [NUM_CMDS-1:0] succ_mask_t;

  function automatic logic is_dram_op(logic [CODE_W-1:0] code);
    return code < CODE_W'(NUM_CMDS);
  endfunction

  // successor mask per previous code, bit n set => code n allowed next
  function automatic succ_mask_t per_bank_succ(logic [CODE_W-1:0] prev);
    case (prev)
      4'd0:        return 11'h084;
      4'd2:        return 11'h078;
      4'd3, 4'd5:  return 11'h179;
      4'd4, 4'd6:  return 11'h284;
      4'd7:        return 11'h604;
      4'd8:        return 11'h0F9;
      4'd9:        return 11'h084;
      4'd10:       return 11'h004;
      default:     return '0;
    endcase
  endfunction

  function automatic succ_mask_t all_bank_succ(logic [CODE_W-1:0] prev);
    case (prev)
      4'd0:                return 11'h004;
      4'd1:                return 11'h080;
      4'd2:                return 11'h078;
      4'd3, 4'd5:          return 11'h17B;
      4'd4, 4'd6, 4'd9,
      4'd10:               return 11'h386;
      4'd7:                return 11'h786;
      4'd8:                return 11'h3FF;
      default:             return '0;
    endcase
  endfunction
endpackage

// File: rtl/dsc_rule_table.sv
module dsc_rule_table
  import dsc_pkg::*;
(
  input  logic [CODE_W-1:0] prev_code,
  input  logic [CODE_W-1:0] curr_code,
  input  logic              all_bank,
  output logic              legal
);
  succ_mask_t mask_pb, mask_ab, mask_sel;

  always_comb begin
    mask_pb  = per_bank_succ(prev_code);
    mask_ab  = all_bank_succ(prev_code);
    mask_sel = all_bank ? mask_ab : mask_pb;
    legal    = 1'b0;
    for (int i = 0; i < NUM_CMDS; i++) begin
      if (curr_code == CODE_W'(i)) legal = mask_sel[i];
    end
  end
endmodule

// File: rtl/dsc_history.sv
module dsc_history
  import dsc_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [CODE_W-1:0] upd_code,
  input  logic [BANK_W-1:0] rd_bank,
  output logic [CODE_W-1:0] rd_code,
  output logic              rd_seen
);
  logic [CODE_W-1:0] last_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] seen_q;
  logic [NUM_BANKS-1:0] wr_en;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign wr_en[b] = upd_en && (upd_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        last_q[b] <= '0;
        seen_q[b] <= 1'b0;
      end else if (wr_en[b]) begin
        last_q[b] <= upd_code;
        seen_q[b] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_code = '0;
    rd_seen = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_bank == BANK_W'(b)) begin
        rd_code = last_q[b];
        rd_seen = seen_q[b];
      end
    end
  end

  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R8
  AST_SEEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_seen && !upd_en |=> $stable(seen_q)); // R7
endmodule

// File: rtl/dram_cmd_order_mon.sv
module dram_cmd_order_mon
  import dsc_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              all_bank_mode,
  output logic              err_pulse,
  output logic [BANK_W-1:0] err_bank,
  output logic [3:0]        err_prev,
  output logic [3:0]        err_curr,
  output logic              err_sticky
);
  logic              bank_ok;
  logic              observed;
  logic [CODE_W-1:0] hist_code;
  logic              hist_seen;
  logic              pair_legal;
  logic              violation;

  if (NUM_BANKS == (1 << BANK_W)) begin : g_full_range
    assign bank_ok = 1'b1;
  end else begin : g_part_range
    assign bank_ok = (cmd_bank < BANK_W'(NUM_BANKS));
  end

  assign observed = cmd_valid && is_dram_op(cmd_code) && bank_ok;

  dsc_history #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (observed),
    .upd_bank (cmd_bank),
    .upd_code (cmd_code),
    .rd_bank  (cmd_bank),
    .rd_code  (hist_code),
    .rd_seen  (hist_seen)
  );

  dsc_rule_table u_rules (
    .prev_code (hist_code),
    .curr_code (cmd_code),
    .all_bank  (all_bank_mode),
    .legal     (pair_legal)
  );

  assign violation = observed && hist_seen && !pair_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_bank   <= '0;
      err_prev   <= '0;
      err_curr   <= '0;
      err_sticky <= 1'b0;
    end else begin
      err_pulse <= violation;
      if (violation) begin
        err_bank   <= cmd_bank;
        err_prev   <= hist_code;
        err_curr   <= cmd_code;
        err_sticky <= 1'b1;
      end
    end
  end

  AST_REPORT_HAS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(cmd_valid)); // R5
  AST_REPORT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_bank == $past(cmd_bank)); // R5
  AST_REPORT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_curr == $past(cmd_code)); // R5
  AST_SKIPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_code > 4'd10) |=> !err_pulse); // R7
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R6
  AST_PULSE_IMPLIES_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky); // R6
endmodule

// File: tb/test_dram_cmd_order_mon.sv
`timescale 1ns/1ps
module test_dram_cmd_order_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [2:0] cmd_bank = '0;
  logic       all_bank_mode = 1'b0;
  logic       err_pulse, err_sticky;
  logic [2:0] err_bank;
  logic [3:0] err_prev, err_curr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [3:0] m_last [8];
  bit         m_seen [8];
  bit         m_sticky;

  always #5 clk = ~clk;

  dram_cmd_order_mon i_dram_cmd_order_mon (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .all_bank_mode(all_bank_mode), .err_pulse(err_pulse),
    .err_bank(err_bank), .err_prev(err_prev), .err_curr(err_curr),
    .err_sticky(err_sticky));

  function automatic bit ok_pair(logic [3:0] p, logic [3:0] c, bit ab);
    if (!ab) begin
      case (p)
        0:     return c inside {2, 7};
        2:     return c inside {3, 4, 5, 6};
        3, 5:  return c inside {0, 3, 4, 5, 6, 8};
        4, 6:  return c inside {2, 7, 9};
        7:     return c inside {2, 9, 10};
        8:     return c inside {0, 3, 4, 5, 6, 7};
        9:     return c inside {2, 7};
        10:    return c == 2;
        default: return 1'b0;
      endcase
    end else begin
      case (p)
        0:     return c == 2;
        1:     return c == 7;
        2:     return c inside {3, 4, 5, 6};
        3, 5:  return c inside {0, 1, 3, 4, 5, 6, 8};
        4, 6, 9, 10: return c inside {1, 2, 7, 8, 9};
        7:     return c inside {1, 2, 7, 8, 9, 10};
        8:     return c <= 9;
        default: return 1'b0;
      endcase
    end
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 8; b++) begin
      m_seen[b] = 1'b0;
      m_last[b] = '0;
    end
    m_sticky = 1'b0;
  endtask

  task automatic issue(bit v, logic [3:0] code, logic [2:0] bank, bit ab, string req);
    bit obs, eb;
    logic [3:0] prev;
    @(negedge clk);
    cmd_valid = v; cmd_code = code; cmd_bank = bank; all_bank_mode = ab;
    obs  = v && (code < 11);
    prev = m_last[bank];
    eb   = obs && m_seen[bank] && !ok_pair(prev, code, ab);
    @(posedge clk);
    #1;
    check(err_pulse == eb, req, err_pulse, eb);
    if (eb) begin
      check(err_bank == bank, {req, " R5 bank"}, err_bank, bank);
      check(err_prev == prev, {req, " R5 prev"}, err_prev, prev);
      check(err_curr == code, {req, " R5 curr"}, err_curr, code);
    end
    m_sticky = m_sticky | eb;
    check(err_sticky == m_sticky, {req, " R6 sticky"}, err_sticky, m_sticky);
    if (obs) begin
      m_seen[bank] = 1'b1;
      m_last[bank] = code;
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check(err_pulse == 1'b0, "R1 pulse in reset", err_pulse, 0);
    check(err_sticky == 1'b0, "R1 sticky in reset", err_sticky, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(err_pulse == 1'b0, "R1 pulse after reset", err_pulse, 0);

    // R2: first command on each bank accepted, even odd codes
    issue(1, 4'd10, 3'd0, 0, "R2 first SREF");
    issue(1, 4'd1,  3'd1, 0, "R2 first PRECHALL");
    // R3 legal per-bank chain on bank 0
    issue(1, 4'd2, 3'd0, 0, "R3 SREF->ACT");
    issue(1, 4'd3, 3'd0, 0, "R3 ACT->RD");
    issue(1, 4'd8, 3'd0, 0, "R3 RD->PDNA");
    issue(1, 4'd7, 3'd0, 0, "R3 PDNA->REF");
    issue(1, 4'd10,3'd0, 0, "R3 REF->SREF");
    // R3 illegal: SREF->RD
    issue(1, 4'd3, 3'd0, 0, "R3 SREF->RD illegal");
    // R8 flagged code kept: RD now history, RD->WR legal
    issue(1, 4'd5, 3'd0, 0, "R8 flagged code stored");
    // R3 precharge-all always flagged in per-bank mode
    issue(1, 4'd0, 3'd1, 0, "R3 PRECHALL->PRE illegal");
    // R7 skipped beats do not touch history
    issue(1, 4'd12, 3'd2, 0, "R7 non-DRAM code");
    issue(0, 4'd0,  3'd0, 0, "R7 valid low");
    issue(1, 4'd0, 3'd0, 0, "R7 history kept WR->PRE");
    // R4 all-bank
    issue(1, 4'd2, 3'd2, 1, "R4 first ACT bank2");
    issue(1, 4'd3, 3'd2, 1, "R4 ACT->RD");
    issue(1, 4'd1, 3'd2, 1, "R4 RD->PRECHALL");
    issue(1, 4'd7, 3'd2, 1, "R4 PRECHALL->REF");
    issue(1, 4'd7, 3'd2, 1, "R4 REF->REF");
    issue(1, 4'd8, 3'd2, 1, "R4 REF->PDNA");
    issue(1, 4'd8, 3'd2, 1, "R4 PDNA->PDNA");
    issue(1, 4'd10,3'd2, 1, "R4 PDNA->SREF illegal");
    // R9 same pair judged per mode: PRE->REF
    issue(1, 4'd0, 3'd3, 1, "R9 first PRE");
    issue(1, 4'd7, 3'd3, 1, "R9 PRE->REF all-bank illegal");
    issue(1, 4'd0, 3'd3, 0, "R9 REF->PRE per-bank illegal");
    issue(1, 4'd7, 3'd3, 0, "R9 PRE->REF per-bank legal");
    // R8 bank independence: bank 4 ACT, bank 5 stuff, bank 4 RD legal
    issue(1, 4'd2, 3'd4, 0, "R8 bank4 ACT");
    issue(1, 4'd9, 3'd5, 0, "R8 bank5 PDNP");
    issue(1, 4'd3, 3'd4, 0, "R8 bank4 ACT->RD");

    // random stream
    for (int i = 0; i < 4000; i++) begin
      bit v, ab;
      logic [3:0] c;
      logic [2:0] bk;
      v  = ($urandom % 8) != 0;
      ab = ($urandom % 64) < 32;
      bk = 3'($urandom % 8);
      if (($urandom % 10) == 0) c = 4'(11 + $urandom % 5);
      else if (m_seen[bk] && ($urandom % 2)) begin
        c = 4'($urandom % 11);
        for (int k = 0; k < 11; k++)
          if (!ok_pair(m_last[bk], c, ab)) c = 4'((c + 1) % 11);
      end else c = 4'($urandom % 11);
      issue(v, c, bk, ab, ab ? "R4 random" : "R3 random");
    end

    // mid-run reset clears history and sticky
    @(negedge clk); rst_n = 1'b0; cmd_valid = 1'b0;
    @(posedge clk); #1;
    check(err_sticky == 1'b0, "R1 sticky cleared", err_sticky, 0);
    check(err_pulse == 1'b0, "R1 pulse cleared", err_pulse, 0);
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    issue(1, 4'd1, 3'd0, 0, "R2 first after re-reset");
    issue(1, 4'd3, 3'd7, 1, "R2 first after re-reset bank7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule